// File: doc/BRIEF.md
# Supply Monitor Reset Controller

This block is the digital side of a supply-voltage supervisor in a small microcontroller. Two analog comparators report whether the supply has dropped below a reset threshold and whether it has dropped below a higher early-warning threshold. The controller synchronizes both signals. It decides when to hold the system in reset and records why the last reset happened. It also reports a supply-OK status bit and raises a warning interrupt when software has enabled it.

Software controls the monitor through two bits, monitor enable and reset select, plus a warning interrupt enable. The enable and select bits are unusual in that they survive software resets and flash-error resets. Only the power-on reset and a supply-fail reset force them back on. While the chip sleeps, both bits read as off and the supply comparator cannot reset the chip. A wake event brings back whatever software last wrote. If a flash erase or write strobe arrives while the monitor is off, the controller issues its own flash-error reset.

Every reset source holds the reset output for a fixed stretch of clock cycles after its condition goes away.

Top module: `supply_guard_ctrl`

## Requirements
- R1: While `por_n` is low, and after it rises, `sys_rst` is 1, `rst_cause` is 3'b001, and `mon_enabled` and `mon_selected` read 1. `sys_rst` falls on the 16th rising clock edge after `por_n` is released, with STRETCH_CYCLES = 16.
- R2: A `ctl_wr` pulse loads the enable, select and interrupt-enable bits. A software reset leaves the enable and select bits unchanged.
- R3: When the monitor is enabled and selected and the synchronized `below_rst_thr` is 1, `sys_rst` is 1 and `rst_cause` is 3'b001. `sys_rst` stays 1 until 16 cycles after the synchronized comparator output returns to 0. This reset forces enable and select to 1.
- R4: When enable is 0 or select is 0, `below_rst_thr` has no effect on `sys_rst`.
- R5: A one-cycle `sw_rst_req` drives `sys_rst` to 1 for exactly 16 cycles and sets `rst_cause` to 3'b010.
- R6: A `flash_wr_strobe` while the monitor is not effectively enabled drives `sys_rst` for 16 cycles and sets `rst_cause` to 3'b100. While the monitor is enabled, the strobe causes no reset.
- R7: After a `sleep_enter` pulse, `mon_enabled` and `mon_selected` read 0 and `below_rst_thr` cannot reset the chip. After a `wake_evt` pulse, both outputs show the last values software wrote, including writes made during sleep.
- R8: `supply_ok` is the inverse of `below_warn_thr` through a two-flop synchronizer. `warn_irq` is 1 exactly when the interrupt enable is 1 and `supply_ok` is 0.
- R9: The select bit can be 1 only while the enable bit is 1. A write that sets select while the stored enable is 0 leaves select at 0, and writing enable as 0 clears select.
- R10: While `sys_rst` is 1, `ctl_wr`, `sw_rst_req` and `sleep_enter` are ignored.
- R11: `rst_cause` is always one-hot. When several causes occur in the same cycle, the priority is supply fail, then flash error, then software.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| below_rst_thr | input | 1 | Comparator: supply below the reset threshold (asynchronous) |
| below_warn_thr | input | 1 | Comparator: supply below the warning threshold (asynchronous) |
| sw_rst_req | input | 1 | Software reset request pulse |
| sleep_enter | input | 1 | Pulse that enters sleep mode |
| wake_evt | input | 1 | Pulse that leaves sleep mode |
| flash_wr_strobe | input | 1 | Flash erase/write attempt |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_mon_en | input | 1 | Write data: monitor enable |
| ctl_mon_sel | input | 1 | Write data: monitor selected as reset source |
| ctl_warn_ie | input | 1 | Write data: warning interrupt enable |
| sys_rst | output | 1 | System reset, active high |
| rst_cause | output | 3 | One-hot last reset cause: bit0 supply/power-on, bit1 software, bit2 flash error |
| supply_ok | output | 1 | Supply above the warning threshold |
| warn_irq | output | 1 | Warning interrupt request (level) |
| mon_enabled | output | 1 | Effective monitor enable (0 during sleep) |
| mon_selected | output | 1 | Effective reset select (0 during sleep) |

## Verification
A corrupted enable or select bit shows up at the ports immediately, through `mon_enabled` and `mon_selected`. Its deeper effect is a supply-fail reset that is missing or unexpected, which appears three clock edges after the comparator changes. A wrong stretch counter shows as `sys_rst` falling one or more cycles early or late relative to the sixteen-cycle window. A wrong cause register shows in `rst_cause` from the first cycle of the reset onward. A sleep flag that does not restore correctly shows on the cycle after the wake pulse, because the effective bits then differ from the last written values.

// File: rtl/supply_guard_pkg.sv
package supply_guard_pkg;

  localparam int CAUSE_W      = 3;
  localparam int CAUSE_SUPPLY = 0;
  localparam int CAUSE_SOFT   = 1;
  localparam int CAUSE_FLASH  = 2;

  typedef logic [CAUSE_W-1:0] cause_t;

  // One-hot cause with fixed priority: supply fail, then flash error, then software.
  function automatic cause_t pick_cause(logic pf, logic fl, logic sw);
    cause_t c;
    c = '0;
    if (pf)      c[CAUSE_SUPPLY] = 1'b1;
    else if (fl) c[CAUSE_FLASH]  = 1'b1;
    else if (sw) c[CAUSE_SOFT]   = 1'b1;
    return c;
  endfunction

  // Select is only accepted while the stored enable is already 1 and stays 1.
  function automatic logic gated_select(logic cur_en, logic wr_en, logic wr_sel);
    return wr_sel & wr_en & cur_en;
  endfunction

endpackage

// File: rtl/sg_sync.sv
module sg_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/sg_ctl_regs.sv
module sg_ctl_regs
  import supply_guard_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic force_on,
  input  logic wr_ok,
  input  logic wr_en_d,
  input  logic wr_sel_d,
  input  logic wr_ie_d,
  input  logic sleep_req,
  input  logic wake_req,
  output logic en_q,
  output logic sel_q,
  output logic ie_q,
  output logic asleep_q,
  output logic eff_en,
  output logic eff_sel
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b1;
      sel_q <= 1'b1;
      ie_q  <= 1'b0;
    end else if (force_on) begin
      en_q  <= 1'b1;
      sel_q <= 1'b1;
    end else if (wr_ok) begin
      en_q  <= wr_en_d;
      sel_q <= gated_select(en_q, wr_en_d, wr_sel_d);
      ie_q  <= wr_ie_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         asleep_q <= 1'b0;
    else if (wake_req)  asleep_q <= 1'b0;
    else if (sleep_req) asleep_q <= 1'b1;
  end

  assign eff_en  = en_q  & ~asleep_q;
  assign eff_sel = sel_q & ~asleep_q;

  assert_sel_needs_en_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    sel_q |-> en_q);

  assert_bits_kept_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    (!force_on && !wr_ok) |=> ($stable(en_q) && $stable(sel_q)));

  assert_forced_on_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    force_on |=> (en_q && sel_q));

endmodule

// File: rtl/sg_rst_seq.sv
module sg_rst_seq
  import supply_guard_pkg::*;
#(
  parameter int STRETCH = 16
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pf_evt,
  input  logic   flash_evt,
  input  logic   sw_evt,
  output logic   sys_rst,
  output cause_t cause_q
);

  localparam int CNT_W = $clog2(STRETCH + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(STRETCH);

  logic             trig;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] stretch_next(logic [CNT_W-1:0] c, logic t);
    if (t)            return LOAD;
    else if (c != '0) return c - 1'b1;
    else              return c;
  endfunction

  assign trig = pf_evt | flash_evt | sw_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= LOAD;
    else        cnt_q <= stretch_next(cnt_q, trig);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cause_q <= cause_t'(1 << CAUSE_SUPPLY);
    else if (trig) cause_q <= pick_cause(pf_evt, flash_evt, sw_evt);
  end

  assign sys_rst = (cnt_q != '0);

  assert_cause_onehot_R11 : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(cause_q));

  assert_trigger_resets_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> sys_rst);

  assert_release_quiet_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst) |-> !$past(trig));

  assert_flash_cause_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    (flash_evt && !pf_evt) |=> cause_q[CAUSE_FLASH]);

endmodule

// File: rtl/supply_guard_ctrl.sv
module supply_guard_ctrl
  import supply_guard_pkg::*;
#(
  parameter int STRETCH_CYCLES = 16,
  parameter int SYNC_STAGES    = 2
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               below_rst_thr,
  input  logic               below_warn_thr,
  input  logic               sw_rst_req,
  input  logic               sleep_enter,
  input  logic               wake_evt,
  input  logic               flash_wr_strobe,
  input  logic               ctl_wr,
  input  logic               ctl_mon_en,
  input  logic               ctl_mon_sel,
  input  logic               ctl_warn_ie,
  output logic               sys_rst,
  output logic [CAUSE_W-1:0] rst_cause,
  output logic               supply_ok,
  output logic               warn_irq,
  output logic               mon_enabled,
  output logic               mon_selected
);

  logic [1:0] cmp_s;
  logic       below_rst_s, below_warn_s;
  logic       en_q, sel_q, ie_q, asleep_q, eff_en, eff_sel;
  logic       pf_evt, flash_evt, sw_evt, wr_ok, sleep_req;
  cause_t     cause_q;

  sg_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (por_n),
    .d     ({below_warn_thr, below_rst_thr}),
    .q     (cmp_s)
  );

  assign below_rst_s  = cmp_s[0];
  assign below_warn_s = cmp_s[1];

  // Named internal events
  assign pf_evt    = eff_en & eff_sel & below_rst_s;
  assign flash_evt = flash_wr_strobe & ~eff_en & ~sys_rst;
  assign sw_evt    = sw_rst_req & ~sys_rst;
  assign wr_ok     = ctl_wr & ~sys_rst;
  assign sleep_req = sleep_enter & ~sys_rst;

  sg_ctl_regs u_ctl (
    .clk       (clk),
    .rst_n     (por_n),
    .force_on  (pf_evt),
    .wr_ok     (wr_ok),
    .wr_en_d   (ctl_mon_en),
    .wr_sel_d  (ctl_mon_sel),
    .wr_ie_d   (ctl_warn_ie),
    .sleep_req (sleep_req),
    .wake_req  (wake_evt),
    .en_q      (en_q),
    .sel_q     (sel_q),
    .ie_q      (ie_q),
    .asleep_q  (asleep_q),
    .eff_en    (eff_en),
    .eff_sel   (eff_sel)
  );

  sg_rst_seq #(.STRETCH(STRETCH_CYCLES)) u_seq (
    .clk       (clk),
    .rst_n     (por_n),
    .pf_evt    (pf_evt),
    .flash_evt (flash_evt),
    .sw_evt    (sw_evt),
    .sys_rst   (sys_rst),
    .cause_q   (cause_q)
  );

  assign rst_cause    = cause_q;
  assign supply_ok    = ~below_warn_s;
  assign warn_irq     = ie_q & below_warn_s;
  assign mon_enabled  = eff_en;
  assign mon_selected = eff_sel;

  assert_no_supply_reset_asleep_R7 : assert property (@(posedge clk) disable iff (!por_n)
    asleep_q |-> !pf_evt);

  assert_irq_needs_warning_R8 : assert property (@(posedge clk) disable iff (!por_n)
    warn_irq |-> !supply_ok);

  assert_writes_blocked_R10 : assert property (@(posedge clk) disable iff (!por_n)
    (sys_rst && !pf_evt && !wake_evt) |=> ($stable(en_q) && $stable(sel_q)));

endmodule

// File: tb/supply_guard_ctrl_tb_top.sv
module supply_guard_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic por_n, below_rst_thr, below_warn_thr, sw_rst_req, sleep_enter, wake_evt;
  logic flash_wr_strobe, ctl_wr, ctl_mon_en, ctl_mon_sel, ctl_warn_ie;
  logic sys_rst, supply_ok, warn_irq, mon_enabled, mon_selected;
  logic [2:0] rst_cause;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  supply_guard_ctrl dut_i (
    .clk(clk), .por_n(por_n), .below_rst_thr(below_rst_thr), .below_warn_thr(below_warn_thr),
    .sw_rst_req(sw_rst_req), .sleep_enter(sleep_enter), .wake_evt(wake_evt),
    .flash_wr_strobe(flash_wr_strobe), .ctl_wr(ctl_wr), .ctl_mon_en(ctl_mon_en),
    .ctl_mon_sel(ctl_mon_sel), .ctl_warn_ie(ctl_warn_ie), .sys_rst(sys_rst),
    .rst_cause(rst_cause), .supply_ok(supply_ok), .warn_irq(warn_irq),
    .mon_enabled(mon_enabled), .mon_selected(mon_selected)
  );

  // {warn_ie, below_warn, exp_supply_ok, exp_warn_irq}
  localparam logic [3:0] WARN_VEC [4] = '{4'b0010, 4'b1010, 4'b1101, 4'b0100};

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic en, input logic sel, input logic ie);
    ctl_wr = 1'b1; ctl_mon_en = en; ctl_mon_sel = sel; ctl_warn_ie = ie;
    cyc(1);
    ctl_wr = 1'b0;
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    cyc(1);
    sig = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    por_n = 1'b0; below_rst_thr = 1'b0; below_warn_thr = 1'b0; sw_rst_req = 1'b0;
    sleep_enter = 1'b0; wake_evt = 1'b0; flash_wr_strobe = 1'b0; ctl_wr = 1'b0;
    ctl_mon_en = 1'b0; ctl_mon_sel = 1'b0; ctl_warn_ie = 1'b0;
    cyc(2);
    // R1 reset state
    chk("R1 rst", sys_rst, 1);
    chk("R1 cause", rst_cause, 3'b001);
    chk("R1 en", mon_enabled, 1);
    chk("R1 sel", mon_selected, 1);
    por_n = 1'b1;
    cyc(15);
    chk("R1 stretch high", sys_rst, 1);
    cyc(1);
    chk("R1 stretch low", sys_rst, 0);

    // R8 vector table
    for (int i = 0; i < 4; i++) begin
      below_warn_thr = WARN_VEC[i][2];
      wr_ctl(1'b1, 1'b1, WARN_VEC[i][3]);
      cyc(2);
      chk("R8 supply_ok", supply_ok, WARN_VEC[i][1]);
      chk("R8 warn_irq", warn_irq, WARN_VEC[i][0]);
    end
    below_warn_thr = 1'b0;
    cyc(3);

    // R2/R5/R10 software reset keeps bits; writes during reset ignored
    wr_ctl(1'b1, 1'b0, 1'b0);
    pulse(sw_rst_req);
    wr_ctl(1'b0, 1'b0, 1'b0);
    cyc(14);
    chk("R5 high", sys_rst, 1);
    chk("R5 cause", rst_cause, 3'b010);
    cyc(1);
    chk("R5 low", sys_rst, 0);
    chk("R10 en kept", mon_enabled, 1);
    chk("R2 sel kept", mon_selected, 0);

    // R4 comparator ignored when not selected / not enabled
    below_rst_thr = 1'b1;
    cyc(5);
    chk("R4 sel0", sys_rst, 0);
    wr_ctl(1'b0, 1'b0, 1'b0);
    cyc(4);
    chk("R4 en0", sys_rst, 0);

    // R9 select gated by enable
    wr_ctl(1'b0, 1'b1, 1'b0);
    chk("R9 sel w/o en", mon_selected, 0);
    wr_ctl(1'b1, 1'b1, 1'b0);
    chk("R9 en set", mon_enabled, 1);
    chk("R9 sel still 0", mon_selected, 0);

    // R3 supply fail reset
    wr_ctl(1'b1, 1'b1, 1'b0);
    cyc(1);
    chk("R3 rst", sys_rst, 1);
    chk("R3 cause", rst_cause, 3'b001);
    below_rst_thr = 1'b0;
    cyc(17);
    chk("R3 hold", sys_rst, 1);
    cyc(1);
    chk("R3 release", sys_rst, 0);
    chk("R3 en", mon_enabled, 1);
    chk("R3 sel", mon_selected, 1);

    // R6 flash error while disabled, R10 sw request ignored during it
    wr_ctl(1'b0, 1'b0, 1'b0);
    pulse(flash_wr_strobe);
    chk("R6 rst", sys_rst, 1);
    chk("R6 cause", rst_cause, 3'b100);
    pulse(sw_rst_req);
    cyc(20);
    chk("R10 cause kept", rst_cause, 3'b100);
    chk("R6 released", sys_rst, 0);

    // R11 priority flash over software
    sw_rst_req = 1'b1; flash_wr_strobe = 1'b1;
    cyc(1);
    sw_rst_req = 1'b0; flash_wr_strobe = 1'b0;
    chk("R11 priority", rst_cause, 3'b100);
    cyc(20);

    // R6 flash with monitor enabled: no reset
    wr_ctl(1'b1, 1'b0, 1'b0);
    pulse(flash_wr_strobe);
    cyc(1);
    chk("R6 no rst", sys_rst, 0);
    chk("R6 cause same", rst_cause, 3'b100);

    // R7 sleep
    wr_ctl(1'b1, 1'b1, 1'b0);
    pulse(sleep_enter);
    chk("R7 en asleep", mon_enabled, 0);
    chk("R7 sel asleep", mon_selected, 0);
    below_rst_thr = 1'b1;
    cyc(5);
    chk("R7 no rst asleep", sys_rst, 0);
    below_rst_thr = 1'b0;
    cyc(3);
    pulse(wake_evt);
    chk("R7 en woke", mon_enabled, 1);
    chk("R7 sel woke", mon_selected, 1);
    pulse(sleep_enter);
    wr_ctl(1'b1, 1'b0, 1'b0);
    pulse(wake_evt);
    chk("R7 sleep write", mon_selected, 0);
    chk("R7 sleep write en", mon_enabled, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule